// File: doc/BRIEF.md
# Dirty Page Bitmap Logger

This block sits beside a device's DMA engine and watches each outgoing memory write. While logging is switched on, it converts the written address into a page number using a programmable power-of-two page size. It then emits a one-byte memory write that flags that page as modified in a bitmap in host memory. Software later scans that bitmap to find which pages must be copied again. Pages map to bits linearly: page 0 (starting at address 0) is bit 0, page 1 is bit 1, and so on. Eight consecutive pages therefore share one bitmap byte.

The block never reads the bitmap. Instead of setting a single bit, it overwrites the whole byte holding the page's bit with 0xFF. This avoids a read-modify-write, at the cost of reporting up to eight neighbouring pages as dirty. A programmable length bounds the bitmap, and marks that would land at or past that length are discarded. Back-to-back writes that fall into the byte most recently marked are folded into a single bitmap write. While a bitmap write waits on the output handshake, the observation stream is stalled, so no mark is lost.

Configuration is done through a small register port with five registers, addressed by `cfg_sel`:
- 0: control, with enable in bit 0.
- 1: bitmap base address.
- 2: bitmap length in bytes.
- 3: page-size exponent.
- 4: address-space tag. This register is writable only when tag support is built in and enabled.

Top module: `dirty_bitmap_logger`

## Requirements
- R1: After a synchronous reset, the registers read as follows: enable 0, base 0, length 0, exponent 12, tag 0. `mark_valid` is 0 and `dma_ready` is 1.
- R2: `cfg_rdata` shows the register selected by `cfg_sel` (0 control bit 0 = enable, 1 base, 2 length, 3 exponent, 4 tag) one clock after the select is applied. A write with `cfg_we` updates the selected register at the clock edge.
- R3: An accepted DMA write at address A produces `mark_addr` = base + ((A >> exponent) >> 3).
- R4: `mark_data` is 0xFF whenever `mark_valid` is 1.
- R5: A DMA write accepted while enable is 0 produces no bitmap write.
- R6: A DMA write whose byte offset ((A >> exponent) >> 3) is at or above the length register produces no bitmap write. An offset of length-1 is still marked.
- R7: A DMA write whose byte offset equals that of the most recently issued mark produces no new bitmap write. Issuing a mark to a different byte replaces the remembered offset.
- R8: The remembered offset is forgotten on reset, on any register write, and while enable is 0. If a register write coincides with an accepted DMA write, that DMA write is judged with the old register values, and the remembered offset is still forgotten.
- R9: While `mark_valid` is 1, `dma_ready` is 0. A pending mark keeps `mark_valid` high and `mark_addr` stable until `mark_ready` is seen high.
- R10: A written exponent below 12 is stored as 12, one above 30 is stored as 30, and values in between are stored as written.
- R11: Writes to the tag register are ignored unless the parameter `TAG_SUPPORTED` is 1 and the input `tag_enable` is 1.
- R12: Clearing enable while a mark is pending does not cancel that mark. It is still delivered once `mark_ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select for write and read |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Registered read data of selected register |
| tag_enable | input | 1 | Address-space tag function enabled |
| dma_valid | input | 1 | Observed DMA write present |
| dma_addr | input | ADDR_W | Byte address of observed DMA write |
| dma_ready | output | 1 | Observation accepted this cycle |
| mark_valid | output | 1 | Bitmap write request pending |
| mark_addr | output | ADDR_W | Byte address of bitmap write |
| mark_data | output | 8 | Data byte of bitmap write |
| mark_ready | input | 1 | Bitmap write accepted |

## Verification
The delicate overlap is a register write that lands in the same cycle as an accepted DMA observation. In that cycle, the mark must use the old base, length and exponent, while the merge memory must also be dropped. The bench drives both strobes on one edge, with the output idle so the observation is certainly taken. It expects the mark at the old mapping, and then expects a second mark when the same byte is hit again. Separately, randomised back-pressure on `mark_ready` makes a mark's acceptance coincide with the next observation waiting. Exact expected address lists are compared to judge this.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_BASE  = 3'd1,
    SEL_LEN   = 3'd2,
    SEL_GRAN  = 3'd3,
    SEL_TAG   = 3'd4
  } cfg_sel_e;

  localparam logic [7:0] MARK_BYTE = 8'hFF;
endpackage

// File: rtl/dbl_regs.sv
module dbl_regs
  import dbl_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 24,
  parameter int TAG_W         = 20,
  parameter int GRAN_MIN      = 12,
  parameter int GRAN_MAX      = 30,
  parameter int GRAN_W        = 5,
  parameter bit TAG_SUPPORTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              tag_enable,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              enable,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W-1:0]  length,
  output logic [GRAN_W-1:0] gran,
  output logic [TAG_W-1:0]  tag,
  output logic              cfg_touched
);
  logic              tag_ok;
  logic [GRAN_W-1:0] gran_next;

  assign tag_ok      = TAG_SUPPORTED && tag_enable;
  assign cfg_touched = cfg_we;

  always_comb begin
    if (cfg_wdata < ADDR_W'(GRAN_MIN))      gran_next = GRAN_W'(GRAN_MIN);
    else if (cfg_wdata > ADDR_W'(GRAN_MAX)) gran_next = GRAN_W'(GRAN_MAX);
    else                                    gran_next = cfg_wdata[GRAN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      base   <= '0;
      length <= '0;
      gran   <= GRAN_W'(GRAN_MIN);
      tag    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL: enable <= cfg_wdata[0];
        SEL_BASE: base   <= cfg_wdata;
        SEL_LEN:  length <= cfg_wdata[LEN_W-1:0];
        SEL_GRAN: gran   <= gran_next;
        SEL_TAG:  if (tag_ok) tag <= cfg_wdata[TAG_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (cfg_sel)
        SEL_CTRL: cfg_rdata <= ADDR_W'(enable);
        SEL_BASE: cfg_rdata <= base;
        SEL_LEN:  cfg_rdata <= ADDR_W'(length);
        SEL_GRAN: cfg_rdata <= ADDR_W'(gran);
        SEL_TAG:  cfg_rdata <= ADDR_W'(tag);
        default:  cfg_rdata <= '0;
      endcase
    end
  end

  // R10
  gran_range_chk: assert property (@(posedge clk) disable iff (rst)
    (gran >= GRAN_W'(GRAN_MIN)) && (gran <= GRAN_W'(GRAN_MAX)));

  // R11
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tag_ok |=> $stable(tag));
endmodule

// File: rtl/dbl_map.sv
module dbl_map #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int GRAN_W = 5
) (
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  length,
  input  logic [GRAN_W-1:0] gran,
  output logic [ADDR_W-1:0] byte_off,
  output logic [ADDR_W-1:0] byte_addr,
  output logic              in_range
);
  logic [ADDR_W-1:0] page_idx;

  assign page_idx  = dma_addr >> gran;
  assign byte_off  = page_idx >> 3;
  assign byte_addr = base + byte_off;
  assign in_range  = byte_off < ADDR_W'(length);
endmodule

// File: rtl/dbl_emit.sv
module dbl_emit
  import dbl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              cfg_touched,
  input  logic              dma_valid,
  output logic              dma_ready,
  input  logic [ADDR_W-1:0] byte_off,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              in_range,
  output logic              mark_valid,
  output logic [ADDR_W-1:0] mark_addr,
  output logic [7:0]        mark_data,
  input  logic              mark_ready
);
  logic [ADDR_W-1:0] last_off;
  logic              last_ok;
  logic              take;
  logic              fire;

  assign dma_ready = !mark_valid;
  assign take      = dma_valid && dma_ready;
  assign fire      = take && enable && in_range && !(last_ok && (byte_off == last_off));
  assign mark_data = MARK_BYTE;

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_valid <= 1'b0;
      mark_addr  <= '0;
      last_off   <= '0;
      last_ok    <= 1'b0;
    end else begin
      if (mark_valid && mark_ready) mark_valid <= 1'b0;
      if (fire) begin
        mark_valid <= 1'b1;
        mark_addr  <= byte_addr;
        last_off   <= byte_off;
        last_ok    <= 1'b1;
      end
      if (cfg_touched || !enable) last_ok <= 1'b0;
    end
  end

  // R9, R12
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mark_valid && !mark_ready) |=> (mark_valid && $stable(mark_addr)));

  // R4
  mark_byte_chk: assert property (@(posedge clk) disable iff (rst)
    mark_valid |-> (mark_data == 8'hFF));

  // R5
  no_mark_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable && !mark_valid) |=> !mark_valid);
endmodule

// File: rtl/dirty_bitmap_logger.sv
module dirty_bitmap_logger #(
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 24,
  parameter int TAG_W         = 20,
  parameter int GRAN_MIN      = 12,
  parameter int GRAN_MAX      = 30,
  parameter bit TAG_SUPPORTED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              tag_enable,
  input  logic              dma_valid,
  input  logic [ADDR_W-1:0] dma_addr,
  output logic              dma_ready,
  output logic              mark_valid,
  output logic [ADDR_W-1:0] mark_addr,
  output logic [7:0]        mark_data,
  input  logic              mark_ready
);
  localparam int GRAN_W = $clog2(GRAN_MAX + 1);

  logic              enable;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  length;
  logic [GRAN_W-1:0] gran;
  logic [TAG_W-1:0]  tag;
  logic              cfg_touched;
  logic [ADDR_W-1:0] byte_off;
  logic [ADDR_W-1:0] byte_addr;
  logic              in_range;

  dbl_regs #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .GRAN_MIN(GRAN_MIN),
    .GRAN_MAX(GRAN_MAX), .GRAN_W(GRAN_W), .TAG_SUPPORTED(TAG_SUPPORTED)
  ) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tag_enable(tag_enable), .cfg_rdata(cfg_rdata),
    .enable(enable), .base(base), .length(length), .gran(gran), .tag(tag),
    .cfg_touched(cfg_touched)
  );

  dbl_map #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .GRAN_W(GRAN_W)) map_i (
    .dma_addr(dma_addr), .base(base), .length(length), .gran(gran),
    .byte_off(byte_off), .byte_addr(byte_addr), .in_range(in_range)
  );

  dbl_emit #(.ADDR_W(ADDR_W)) emit_i (
    .clk(clk), .rst(rst), .enable(enable), .cfg_touched(cfg_touched),
    .dma_valid(dma_valid), .dma_ready(dma_ready), .byte_off(byte_off),
    .byte_addr(byte_addr), .in_range(in_range), .mark_valid(mark_valid),
    .mark_addr(mark_addr), .mark_data(mark_data), .mark_ready(mark_ready)
  );
endmodule

// File: tb/dirty_bitmap_logger_tb.sv
module dirty_bitmap_logger_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = 3'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          tag_enable = 1'b0;
  logic          dma_valid = 1'b0;
  logic [AW-1:0] dma_addr = '0;
  logic          dma_ready;
  logic          mark_valid;
  logic [AW-1:0] mark_addr;
  logic [7:0]    mark_data;
  logic          mark_ready = 1'b1;

  int tests = 0, fails = 0, cycles = 0;
  logic [AW-1:0] got [0:255];
  logic [AW-1:0] expv [0:255];
  int got_n = 0, exp_n = 0;
  bit bp_on = 0;
  logic [15:0] lfsr = 16'hACE1;

  // bench model of registers and merge memory
  bit m_en = 0; logic [AW-1:0] m_base = 0; int m_len = 0; int m_gran = 12;
  bit m_lok = 0; logic [AW-1:0] m_loff = 0;

  dirty_bitmap_logger dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tag_enable(tag_enable), .dma_valid(dma_valid),
    .dma_addr(dma_addr), .dma_ready(dma_ready), .mark_valid(mark_valid),
    .mark_addr(mark_addr), .mark_data(mark_data), .mark_ready(mark_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst && mark_valid && mark_ready && got_n < 256) begin
      got[got_n] = mark_addr;
      got_n++;
    end
  end

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (bp_on) mark_ready = lfsr[0] | lfsr[3];
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog (all): act=hang exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic int clamp_gran(logic [AW-1:0] v);
    if (v < 12) return 12;
    if (v > 30) return 30;
    return int'(v);
  endfunction

  task automatic model_dma(logic [AW-1:0] a);
    logic [AW-1:0] off;
    off = (a >> m_gran) >> 3;
    if (m_en && off < AW'(m_len) && !(m_lok && off == m_loff)) begin
      expv[exp_n] = m_base + off; exp_n++;
      m_loff = off; m_lok = 1;
    end
  endtask

  task automatic model_cfg(logic [2:0] s, logic [AW-1:0] d);
    case (s)
      3'd0: m_en = d[0];
      3'd1: m_base = d;
      3'd2: m_len = int'(d[23:0]);
      3'd3: m_gran = clamp_gran(d);
      default: ;
    endcase
    m_lok = 0;
  endtask

  task automatic cfg_wr(logic [2:0] s, logic [AW-1:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    model_cfg(s, d);
  endtask

  task automatic rd(logic [2:0] s, output logic [AW-1:0] v);
    @(posedge clk); #1;
    cfg_sel = s;
    @(posedge clk);
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic dma(logic [AW-1:0] a);
    @(posedge clk); #1;
    dma_valid = 1; dma_addr = a;
    forever begin
      @(negedge clk);
      if (dma_ready) break;
    end
    @(posedge clk); #1;
    dma_valid = 0;
    model_dma(a);
  endtask

  task automatic drain();
    bit saved;
    saved = bp_on; bp_on = 0; mark_ready = 1;
    repeat (4) @(negedge clk);
    bp_on = saved;
  endtask

  task automatic start_scn();
    drain();
    got_n = 0; exp_n = 0;
  endtask

  task automatic end_scn(string req);
    drain();
    check({req, " count"}, AW'(got_n), AW'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) check(req, got[i], expv[i]);
  endtask

  initial begin
    logic [AW-1:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    @(negedge clk);
    check("R1 mark_valid", AW'(mark_valid), 0);
    check("R1 dma_ready", AW'(dma_ready), 1);
    rd(3'd0, v); check("R1 enable", v, 0);
    rd(3'd1, v); check("R1 base", v, 0);
    rd(3'd2, v); check("R1 length", v, 0);
    rd(3'd3, v); check("R1 gran", v, 12);
    rd(3'd4, v); check("R1 tag", v, 0);

    // R2 / R10 register writes and exponent clamp
    cfg_wr(3'd1, 32'h8000_0000); rd(3'd1, v); check("R2 base", v, 32'h8000_0000);
    cfg_wr(3'd2, 32'd5);         rd(3'd2, v); check("R2 length", v, 5);
    cfg_wr(3'd3, 32'd5);         rd(3'd3, v); check("R10 low clamp", v, 12);
    cfg_wr(3'd3, 32'd31);        rd(3'd3, v); check("R10 high clamp", v, 30);
    cfg_wr(3'd3, 32'd200);       rd(3'd3, v); check("R10 high clamp far", v, 30);
    cfg_wr(3'd3, 32'd17);        rd(3'd3, v); check("R10 in range", v, 17);

    // R11 tag gating
    cfg_wr(3'd4, 32'h123);       rd(3'd4, v); check("R11 tag ignored", v, 0);
    tag_enable = 1;
    cfg_wr(3'd4, 32'h456);       rd(3'd4, v); check("R11 tag written", v, 32'h456);
    tag_enable = 0;
    cfg_wr(3'd4, 32'h789);       rd(3'd4, v); check("R11 tag ignored again", v, 32'h456);

    // R5 disabled: no marks
    start_scn();
    cfg_wr(3'd3, 12);
    for (int p = 0; p < 16; p++) dma(AW'(p) << 12);
    end_scn("R5 disabled");

    // R3 R6 R7 sweep over exponents with back-pressure
    bp_on = 1;
    for (int g = 12; g <= 15; g++) begin
      start_scn();
      cfg_wr(3'd1, 32'h4000_0000 + AW'(g) * 32'h100);
      cfg_wr(3'd2, 3);
      cfg_wr(3'd3, AW'(g));
      cfg_wr(3'd0, 1);
      for (int p = 0; p < 36; p++) dma((AW'(p) << g) + AW'(p * 7));
      end_scn("R3 R6 R7 sweep");
    end
    bp_on = 0;

    // R6 boundary: offset length-1 marked, length dropped
    start_scn();
    cfg_wr(3'd2, 4);
    dma(AW'(31) << 15);   // offset 3
    dma(AW'(32) << 15);   // offset 4 dropped
    dma(AW'(200) << 15);  // dropped
    end_scn("R6 boundary");

    // R7 merge: A A B A
    start_scn();
    dma(AW'(0) << 15); dma(AW'(5) << 15); dma(AW'(8) << 15); dma(AW'(1) << 15);
    end_scn("R7 merge");

    // R8 register write forgets merge
    start_scn();
    dma(AW'(9) << 15);
    cfg_wr(3'd2, 4);
    dma(AW'(9) << 15);
    end_scn("R8 forget on write");

    // R8 collision: register write and DMA in same cycle
    start_scn();
    dma(AW'(16) << 15);
    drain();
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = 3'd1; cfg_wdata = 32'h5000_0000;
    dma_valid = 1; dma_addr = AW'(17) << 15;
    @(posedge clk); #1;
    cfg_we = 0; dma_valid = 0;
    model_dma(AW'(17) << 15);   // old base, merged away
    model_cfg(3'd1, 32'h5000_0000);
    dma(AW'(17) << 15);         // new base, must issue
    end_scn("R8 collision");

    // R9 / R12 stall and disable while pending
    start_scn();
    mark_ready = 0;
    dma(AW'(0) << 15);
    @(negedge clk);
    check("R9 dma_ready low", AW'(dma_ready), 0);
    check("R9 pending", AW'(mark_valid), 1);
    cfg_wr(3'd0, 0);
    repeat (3) @(negedge clk);
    check("R12 still pending", AW'(mark_valid), 1);
    check("R12 addr held", mark_addr, 32'h5000_0000);
    check("R4 data", AW'(mark_data), 32'hFF);
    mark_ready = 1;
    dma(AW'(24) << 15);
    end_scn("R12 delivered");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule